// File: doc/BRIEF.md
# I2C Message Sequencer with Block Read

This block runs a whole list of I2C messages with no software involvement per byte. Each message is described by a 7-bit target address, a direction, a byte length and a block-read flag. The sequencer fetches descriptors by index through a small combinational lookup port. It opens the first message with a START and each later one with a repeated START, and it closes the transfer with a STOP. Bytes to transmit come from an external write FIFO. Received bytes go to an external read FIFO.

Below the sequencer sits a byte-level bus master with a simple command/event handshake. The sequencer issues one command per byte: address, write, read (with the acknowledge to send) or stop. For every byte except stop, the master answers with exactly one event that reports completion, lost arbitration, the received acknowledge and the received byte. The decision to send NACK is made when the command for the final byte is issued. In block-read mode the first received byte extends the read length while the transfer runs. At the end, a 3-bit result code and a done pulse report the outcome. A watchdog aborts a transfer whose byte master stays silent.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset busy, done, rd_push and bm_cmd_valid are low and result is 0.
- R2: Each message opens with a command of op code 0 whose data is the address shifted left by one, ORed with 1 for a read. The rs flag is 0 for message index 0 and 1 for every later message. A command stays valid and unchanged until bm_cmd_ready accepts it.
- R3: A write message of length L issues L commands of op code 1. Each carries the current write-FIFO byte, and wr_pop pulses once per accepted write command.
- R4: Each read-data event that reports completion without lost arbitration places its byte on rd_data with rd_push high in the following cycle, in arrival order.
- R5: Read commands use op code 2. Their nack flag is set only on the command that fetches byte index L-1 of the message. This includes the first command when L is 1 and block mode is off.
- R6: In block mode the first received byte B, if 1 to BLK_MAX, is pushed and the message length becomes the length field plus B. The nack flag of the first read command is always clear in this mode.
- R7: In block mode a first byte of 0 or above BLK_MAX is not pushed, and the transfer ends with result 4.
- R8: Each event is checked in this priority order. Not complete gives result 1. Lost arbitration gives result 2. A received NACK after an address or write byte gives result 3. A received NACK on a read-data event is ignored. Any error ends the transfer.
- R9: Every transfer, good or failed, ends with exactly one command of op code 3. One cycle after that command is accepted, done pulses with busy low. The result is 0 when no error occurred.
- R10: If no event arrives for TMO_CYCLES cycles while one is awaited, the transfer ends with result 5.
- R11: A message of length 0 that is not a block read issues no data command. The next address command or the stop command follows directly after its address event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a transfer when idle |
| msg_count | input | MSG_W | Number of messages, at least 1 |
| msg_sel | output | MSG_W | Index of the descriptor being fetched |
| msg_addr | input | 7 | Target address of the selected message |
| msg_rd | input | 1 | Selected message is a read |
| msg_blk | input | 1 | Selected read is a block read |
| msg_len | input | LEN_W | Byte length of the selected message |
| wr_valid | input | 1 | Write FIFO holds a byte |
| wr_data | input | 8 | Head byte of the write FIFO |
| wr_pop | output | 1 | Consume the write FIFO head |
| rd_push | output | 1 | Received byte valid |
| rd_data | output | 8 | Received byte |
| bm_cmd_valid | output | 1 | Command to byte master valid |
| bm_cmd_ready | input | 1 | Byte master accepts command |
| bm_cmd_op | output | 2 | 0 address, 1 write, 2 read, 3 stop |
| bm_cmd_rs | output | 1 | Address command is a repeated START |
| bm_cmd_data | output | 8 | Address or write byte |
| bm_cmd_nack | output | 1 | Send NACK after the byte being read |
| bm_evt_valid | input | 1 | Byte event from byte master |
| bm_evt_done | input | 1 | Byte transfer completed |
| bm_evt_arb | input | 1 | Arbitration lost |
| bm_evt_nack | input | 1 | NACK received |
| bm_evt_data | input | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 I/O, 2 arbitration, 3 NACK, 4 protocol, 5 timeout |

## Verification
A command shows on the bm_cmd outputs combinationally in the cycle the sequencer enters an issue state. The pushed byte, the done pulse and the result appear one clock after the edge that saw the event or the stop acceptance. The bench drives inputs and samples outputs on the falling edge. It answers each logged command with an event one edge after acceptance, so every registered result is read exactly once, in the cycle it is due. Expected command streams, pushed bytes, pops and result codes come from an arithmetic walk of the message list that applies the injected fault at its command index.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bm_op_e;

    typedef enum logic [2:0] {
        RES_OK    = 3'd0,
        RES_IO    = 3'd1,
        RES_ARB   = 3'd2,
        RES_NACK  = 3'd3,
        RES_PROTO = 3'd4,
        RES_TMO   = 3'd5
    } seq_res_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_W,
        S_RD,
        S_RD_W,
        S_WR,
        S_WR_W,
        S_STOP
    } seq_st_e;

endpackage

// File: rtl/i2c_seq_tmo.sv
module i2c_seq_tmo #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (!arm || kick) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(LIMIT - 1)) begin
            expire = 1'b1;
            cnt_d  = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: the wait counter never passes its limit
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

    // R10: an expiry drops the counter back to zero
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt_q == '0);

endmodule

// File: rtl/i2c_seq_eval.sv
module i2c_seq_eval
    import i2c_seq_pkg::*;
(
    input  logic     ev_done,
    input  logic     ev_arb,
    input  logic     ev_nack,
    input  logic     want_ack,
    output logic     fail,
    output seq_res_e code
);
    always_comb begin
        fail = 1'b1;
        code = RES_OK;
        if (!ev_done) begin
            code = RES_IO;
        end else if (ev_arb) begin
            code = RES_ARB;
        end else if (want_ack && ev_nack) begin
            code = RES_NACK;
        end else begin
            fail = 1'b0;
        end
    end
endmodule

// File: rtl/i2c_seq_rlen.sv
module i2c_seq_rlen #(
    parameter int LEN_W   = 8,
    parameter int BLK_MAX = 32
) (
    input  logic [LEN_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    input  logic             blk,
    input  logic [7:0]       rx_byte,
    output logic             nack_cmd,
    output logic             blk_bad,
    output logic [LEN_W-1:0] len_next,
    output logic             last
);
    localparam logic [7:0] BLK_LIM = 8'(BLK_MAX);

    logic first_blk;

    always_comb begin
        first_blk = blk && (pos == '0);
        // the acknowledge choice travels with the command that fetches the byte
        nack_cmd  = !first_blk && (pos == len - LEN_W'(1));
        blk_bad   = first_blk && ((rx_byte == 8'd0) || (rx_byte > BLK_LIM));
        len_next  = first_blk ? len + LEN_W'(rx_byte) : len;
        last      = (pos + LEN_W'(1)) == len_next;
    end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
    import i2c_seq_pkg::*;
#(
    parameter int MSG_W      = 2,
    parameter int LEN_W      = 8,
    parameter int BLK_MAX    = 32,
    parameter int TMO_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [MSG_W-1:0] msg_count,
    output logic [MSG_W-1:0] msg_sel,
    input  logic [6:0]       msg_addr,
    input  logic             msg_rd,
    input  logic             msg_blk,
    input  logic [LEN_W-1:0] msg_len,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             wr_pop,
    output logic             rd_push,
    output logic [7:0]       rd_data,
    output logic             bm_cmd_valid,
    input  logic             bm_cmd_ready,
    output logic [1:0]       bm_cmd_op,
    output logic             bm_cmd_rs,
    output logic [7:0]       bm_cmd_data,
    output logic             bm_cmd_nack,
    input  logic             bm_evt_valid,
    input  logic             bm_evt_done,
    input  logic             bm_evt_arb,
    input  logic             bm_evt_nack,
    input  logic [7:0]       bm_evt_data,
    output logic             busy,
    output logic             done,
    output logic [2:0]       result
);
    typedef struct packed {
        seq_st_e          st;
        logic [MSG_W-1:0] idx;
        logic [MSG_W-1:0] cnt;
        logic [LEN_W-1:0] pos;
        logic [LEN_W-1:0] len;
        logic             rd;
        logic             blk;
        seq_res_e         res;
        logic             done;
        logic             push;
        logic [7:0]       pdat;
    } seq_t;

    seq_t q, n;

    logic     waiting, expire, fail, want_ack;
    seq_res_e code;
    logic     nack_cmd, blk_bad, last;
    logic [LEN_W-1:0] len_next;
    logic     msg_end;
    bm_op_e   op;

    assign waiting  = (q.st == S_ADDR_W) || (q.st == S_RD_W) || (q.st == S_WR_W);
    assign want_ack = (q.st == S_ADDR_W) || (q.st == S_WR_W);

    i2c_seq_tmo #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (waiting),
        .kick   (bm_evt_valid),
        .expire (expire)
    );

    i2c_seq_eval u_eval (
        .ev_done  (bm_evt_done),
        .ev_arb   (bm_evt_arb),
        .ev_nack  (bm_evt_nack),
        .want_ack (want_ack),
        .fail     (fail),
        .code     (code)
    );

    i2c_seq_rlen #(.LEN_W(LEN_W), .BLK_MAX(BLK_MAX)) u_rlen (
        .pos      (q.pos),
        .len      (q.len),
        .blk      (q.blk),
        .rx_byte  (bm_evt_data),
        .nack_cmd (nack_cmd),
        .blk_bad  (blk_bad),
        .len_next (len_next),
        .last     (last)
    );

    always_comb begin
        n            = q;
        n.done       = 1'b0;
        n.push       = 1'b0;
        msg_end      = 1'b0;
        bm_cmd_valid = 1'b0;
        op           = OP_ADDR;
        bm_cmd_rs    = 1'b0;
        bm_cmd_data  = 8'd0;
        bm_cmd_nack  = 1'b0;
        wr_pop       = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (go) begin
                    n.st  = S_ADDR;
                    n.idx = '0;
                    n.cnt = msg_count;
                    n.res = RES_OK;
                end
            end
            S_ADDR: begin
                bm_cmd_valid = 1'b1;
                op           = OP_ADDR;
                bm_cmd_rs    = (q.idx != '0);
                bm_cmd_data  = {msg_addr, msg_rd};
                n.len        = msg_len;
                n.rd         = msg_rd;
                n.blk        = msg_blk;
                n.pos        = '0;
                if (bm_cmd_ready) n.st = S_ADDR_W;
            end
            S_ADDR_W: begin
                if (expire) begin
                    n.res = RES_TMO;
                    n.st  = S_STOP;
                end else if (bm_evt_valid) begin
                    if (fail) begin
                        n.res = code;
                        n.st  = S_STOP;
                    end else if (q.rd && (q.blk || q.len != '0)) begin
                        n.st = S_RD;
                    end else if (!q.rd && q.len != '0) begin
                        n.st = S_WR;
                    end else begin
                        msg_end = 1'b1;
                    end
                end
            end
            S_RD: begin
                bm_cmd_valid = 1'b1;
                op           = OP_READ;
                bm_cmd_nack  = nack_cmd;
                if (bm_cmd_ready) n.st = S_RD_W;
            end
            S_RD_W: begin
                if (expire) begin
                    n.res = RES_TMO;
                    n.st  = S_STOP;
                end else if (bm_evt_valid) begin
                    if (fail) begin
                        n.res = code;
                        n.st  = S_STOP;
                    end else if (blk_bad) begin
                        n.res = RES_PROTO;
                        n.st  = S_STOP;
                    end else begin
                        n.push = 1'b1;
                        n.pdat = bm_evt_data;
                        n.len  = len_next;
                        n.pos  = q.pos + LEN_W'(1);
                        if (last) msg_end = 1'b1;
                        else      n.st    = S_RD;
                    end
                end
            end
            S_WR: begin
                bm_cmd_valid = wr_valid;
                op           = OP_WRITE;
                bm_cmd_data  = wr_data;
                if (wr_valid && bm_cmd_ready) begin
                    wr_pop = 1'b1;
                    n.st   = S_WR_W;
                end
            end
            S_WR_W: begin
                if (expire) begin
                    n.res = RES_TMO;
                    n.st  = S_STOP;
                end else if (bm_evt_valid) begin
                    if (fail) begin
                        n.res = code;
                        n.st  = S_STOP;
                    end else begin
                        n.pos = q.pos + LEN_W'(1);
                        if ((q.pos + LEN_W'(1)) == q.len) msg_end = 1'b1;
                        else                               n.st    = S_WR;
                    end
                end
            end
            S_STOP: begin
                bm_cmd_valid = 1'b1;
                op           = OP_STOP;
                if (bm_cmd_ready) begin
                    n.st   = S_IDLE;
                    n.done = 1'b1;
                end
            end
            default: n.st = S_IDLE;
        endcase

        if (msg_end) begin
            if (q.idx == q.cnt - MSG_W'(1)) begin
                n.st = S_STOP;
            end else begin
                n.idx = q.idx + MSG_W'(1);
                n.st  = S_ADDR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, res: RES_OK, default: '0};
        end else begin
            q <= n;
        end
    end

    assign bm_cmd_op = op;
    assign msg_sel   = q.idx;
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;
    assign result    = q.res;
    assign rd_push   = q.push;
    assign rd_data   = q.pdat;

    // R2: a stalled non-write command holds its op and byte
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_cmd_valid && !bm_cmd_ready && op != OP_WRITE)
        |=> (bm_cmd_valid && $stable(bm_cmd_op) && $stable(bm_cmd_data)));

    // R9: the completion pulse never overlaps an active transfer
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: the done pulse follows an accepted stop command
    a_r9_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bm_cmd_valid && bm_cmd_ready && op == OP_STOP));

    // R8: an incomplete address byte wins over every other fault
    a_r8_io_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ADDR_W && bm_evt_valid && !bm_evt_done)
        |=> (q.st == S_STOP && q.res == RES_IO));

    // R7: an out-of-range block count is rejected and not stored
    a_r7_blk_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RD_W && bm_evt_valid && bm_evt_done && !bm_evt_arb &&
         q.blk && q.pos == '0 &&
         (bm_evt_data == 8'd0 || bm_evt_data > 8'(BLK_MAX)))
        |=> (q.res == RES_PROTO && !rd_push));

    // R4: a pushed byte always stems from a read event one cycle earlier
    a_r4_push_src: assert property (@(posedge clk) disable iff (!rst_n)
        rd_push |-> $past(q.st == S_RD_W && bm_evt_valid && bm_evt_done && !bm_evt_arb));

endmodule

// File: tb/i2c_msg_seq_tb.sv
module i2c_msg_seq_tb;
    localparam int MSG_W = 2;
    localparam int LEN_W = 8;
    localparam int NMAX  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [MSG_W-1:0] msg_count = '0;
    logic [MSG_W-1:0] msg_sel;
    logic [6:0] msg_addr;
    logic msg_rd, msg_blk;
    logic [LEN_W-1:0] msg_len;
    logic wr_valid = 1'b1;
    logic [7:0] wr_data;
    logic wr_pop, rd_push;
    logic [7:0] rd_data;
    logic bm_cmd_valid;
    logic bm_cmd_ready = 1'b1;
    logic [1:0] bm_cmd_op;
    logic bm_cmd_rs;
    logic [7:0] bm_cmd_data;
    logic bm_cmd_nack;
    logic bm_evt_valid = 1'b0, bm_evt_done = 1'b0, bm_evt_arb = 1'b0, bm_evt_nack = 1'b0;
    logic [7:0] bm_evt_data = 8'd0;
    logic busy, done;
    logic [2:0] result;

    always #5 clk = ~clk;

    logic [6:0]       d_addr [4];
    logic             d_rd   [4];
    logic             d_blk  [4];
    logic [LEN_W-1:0] d_len  [4];
    int wr_rd = 0;
    int blk_first = -1;
    int cur_blkv = 0;

    function automatic logic [7:0] wval(input int i);
        return 8'((i * 53 + 17) & 255);
    endfunction

    function automatic logic [7:0] rdat(input int i);
        if (i == blk_first) return 8'(cur_blkv);
        return 8'((i * 29 + 3) & 255);
    endfunction

    assign msg_addr = d_addr[msg_sel];
    assign msg_rd   = d_rd[msg_sel];
    assign msg_blk  = d_blk[msg_sel];
    assign msg_len  = d_len[msg_sel];
    assign wr_data  = wval(wr_rd);

    i2c_msg_seq #(.MSG_W(MSG_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .go(go), .msg_count(msg_count), .msg_sel(msg_sel),
        .msg_addr(msg_addr), .msg_rd(msg_rd), .msg_blk(msg_blk), .msg_len(msg_len),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_pop(wr_pop),
        .rd_push(rd_push), .rd_data(rd_data),
        .bm_cmd_valid(bm_cmd_valid), .bm_cmd_ready(bm_cmd_ready), .bm_cmd_op(bm_cmd_op),
        .bm_cmd_rs(bm_cmd_rs), .bm_cmd_data(bm_cmd_data), .bm_cmd_nack(bm_cmd_nack),
        .bm_evt_valid(bm_evt_valid), .bm_evt_done(bm_evt_done), .bm_evt_arb(bm_evt_arb),
        .bm_evt_nack(bm_evt_nack), .bm_evt_data(bm_evt_data),
        .busy(busy), .done(done), .result(result)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected stream
    int e_op [NMAX]; int e_rs [NMAX]; int e_dat [NMAX]; int e_nk [NMAX];
    int e_n, e_push [NMAX], e_np, e_res, e_pops;
    // observed stream
    int g_op [NMAX]; int g_rs [NMAX]; int g_dat [NMAX]; int g_nk [NMAX];
    int g_n, g_push [NMAX], g_np, g_pops;

    task automatic add(input int op, input int rs, input int dat, input int nk);
        e_op[e_n] = op; e_rs[e_n] = rs; e_dat[e_n] = dat; e_nk[e_n] = nk;
        e_n++;
    endtask

    function automatic int errc(input int ek, input int ea, input int i, input bit ack);
        if (i != ea) return 0;
        case (ek)
            1: return 1;
            2: return 2;
            3: return ack ? 3 : 0;
            4: return 5;
            default: return 0;
        endcase
    endfunction

    task automatic model(input int nm, input int ek, input int ea, input int blkv);
        int wi; bit stop; int len; int r; int d;
        e_n = 0; e_np = 0; e_res = 0; e_pops = 0; wi = 0; stop = 0;
        blk_first = -1; cur_blkv = blkv;
        for (int m = 0; m < nm && !stop; m++) begin
            add(0, (m != 0) ? 1 : 0, int'({d_addr[m], d_rd[m]}), 0);
            r = errc(ek, ea, e_n - 1, 1'b1);
            if (r != 0) begin
                e_res = r; stop = 1;
            end else if (d_rd[m]) begin
                len = int'(d_len[m]);
                if (d_blk[m] || len != 0) begin
                    for (int p = 0; !stop; p++) begin
                        add(2, 0, 0, (!(d_blk[m] && p == 0) && (p == len - 1)) ? 1 : 0);
                        r = errc(ek, ea, e_n - 1, 1'b0);
                        if (r != 0) begin
                            e_res = r; stop = 1;
                        end else begin
                            if (d_blk[m] && p == 0) begin
                                blk_first = e_n - 1;
                                d = blkv;
                                if (d == 0 || d > 32) begin e_res = 4; stop = 1; end
                                else len = len + d;
                            end else begin
                                d = int'(rdat(e_n - 1));
                            end
                            if (!stop) begin
                                e_push[e_np] = d; e_np++;
                                if (p + 1 == len) break;
                            end
                        end
                    end
                end
            end else begin
                for (int p = 0; p < int'(d_len[m]) && !stop; p++) begin
                    add(1, 0, int'(wval(wi)), 0);
                    wi++; e_pops++;
                    r = errc(ek, ea, e_n - 1, 1'b1);
                    if (r != 0) begin e_res = r; stop = 1; end
                end
            end
        end
        add(3, 0, 0, 0);
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic run(input string tag, input int nm, input int ek, input int ea, input int blkv);
        bit fin; bit newc; bit pend; int pidx; int res_got; int busy_at_done; int lim;
        model(nm, ek, ea, blkv);
        g_n = 0; g_np = 0; g_pops = 0; wr_rd = 0;
        fin = 0; pend = 0; pidx = 0; res_got = -1; busy_at_done = 1;
        msg_count = MSG_W'(nm);
        @(negedge clk);
        go = 1'b1;
        for (int t = 0; t < 3000 && !fin; t++) begin
            @(negedge clk);
            newc = 0;
            if (bm_cmd_valid && g_n < NMAX) begin
                g_op[g_n] = int'(bm_cmd_op); g_rs[g_n] = int'(bm_cmd_rs);
                g_dat[g_n] = int'(bm_cmd_data); g_nk[g_n] = int'(bm_cmd_nack);
                g_n++;
                newc = (bm_cmd_op != 2'd3);
            end
            if (rd_push && g_np < NMAX) begin g_push[g_np] = int'(rd_data); g_np++; end
            if (wr_pop) begin g_pops++; wr_rd++; end
            if (done) begin fin = 1; res_got = int'(result); busy_at_done = int'(busy); end
            go = 1'b0;
            bm_evt_valid = 1'b0; bm_evt_done = 1'b0; bm_evt_arb = 1'b0; bm_evt_nack = 1'b0;
            if (pend) begin
                pend = 0;
                if (!(ek == 4 && pidx == ea)) begin
                    bm_evt_valid = 1'b1;
                    bm_evt_done  = !(ek == 1 && pidx == ea);
                    bm_evt_arb   = (ek == 2 && pidx == ea);
                    bm_evt_nack  = (ek == 3 && pidx == ea);
                    bm_evt_data  = rdat(pidx);
                end
            end
            if (newc) begin pend = 1; pidx = g_n - 1; end
        end
        chk(fin == 1, "R9", {tag, " done pulse seen"}, fin, 1);
        chk(res_got == e_res, tag, "result code", res_got, e_res);
        chk(busy_at_done == 0, "R9", "busy low at done", busy_at_done, 0);
        chk(g_n == e_n, "R9", "command count", g_n, e_n);
        lim = (g_n < e_n) ? g_n : e_n;
        for (int i = 0; i < lim; i++) begin
            chk(g_op[i] == e_op[i], op_tag(e_op[i]), "command op", g_op[i], e_op[i]);
            if (e_op[i] == 0) begin
                chk(g_rs[i] == e_rs[i], "R2", "repeated start flag", g_rs[i], e_rs[i]);
                chk(g_dat[i] == e_dat[i], "R2", "address byte", g_dat[i], e_dat[i]);
            end else if (e_op[i] == 1) begin
                chk(g_dat[i] == e_dat[i], "R3", "write byte", g_dat[i], e_dat[i]);
            end else if (e_op[i] == 2) begin
                chk(g_nk[i] == e_nk[i], "R5", "read nack flag", g_nk[i], e_nk[i]);
            end
        end
        chk(g_np == e_np, "R4", "pushed byte count", g_np, e_np);
        lim = (g_np < e_np) ? g_np : e_np;
        for (int i = 0; i < lim; i++)
            chk(g_push[i] == e_push[i], "R4", "pushed byte", g_push[i], e_push[i]);
        chk(g_pops == e_pops, "R3", "write pops", g_pops, e_pops);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_msg(input int m, input logic [6:0] a, input bit rd, input bit blk, input int len);
        d_addr[m] = a; d_rd[m] = rd; d_blk[m] = blk; d_len[m] = LEN_W'(len);
    endtask

    initial begin
        automatic int bl[7] = '{1, 2, 3, 32, 0, 33, 255};
        for (int m = 0; m < 4; m++) set_msg(m, 7'h00, 1'b0, 1'b0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(bm_cmd_valid == 1'b0, "R1", "cmd valid after reset", int'(bm_cmd_valid), 0);
        chk(rd_push == 1'b0, "R1", "push after reset", int'(rd_push), 0);
        chk(result == 3'd0, "R1", "result after reset", int'(result), 0);

        for (int len = 0; len < 4; len++) begin
            set_msg(0, 7'h50, 1'b0, 1'b0, len);
            run((len == 0) ? "R11" : "R3", 1, 0, 0, 0);
        end
        for (int len = 0; len < 5; len++) begin
            set_msg(0, 7'h2C, 1'b1, 1'b0, len);
            run((len == 0) ? "R11" : "R5", 1, 0, 0, 0);
        end
        set_msg(0, 7'h1A, 1'b0, 1'b0, 2);
        set_msg(1, 7'h1A, 1'b1, 1'b0, 3);
        run("R2", 2, 0, 0, 0);
        set_msg(0, 7'h11, 1'b1, 1'b0, 0);
        set_msg(1, 7'h22, 1'b0, 1'b0, 1);
        set_msg(2, 7'h33, 1'b1, 1'b0, 2);
        run("R11", 3, 0, 0, 0);
        foreach (bl[k]) begin
            set_msg(0, 7'h3B, 1'b1, 1'b1, 1);
            run((bl[k] >= 1 && bl[k] <= 32) ? "R6" : "R7", 1, 0, 0, bl[k]);
        end
        set_msg(0, 7'h3B, 1'b0, 1'b0, 1);
        set_msg(1, 7'h3B, 1'b1, 1'b1, 1);
        run("R6", 2, 0, 0, 5);
        set_msg(0, 7'h48, 1'b0, 1'b0, 2);
        set_msg(1, 7'h48, 1'b1, 1'b0, 2);
        for (int ek = 1; ek <= 4; ek++)
            for (int ea = 0; ea < 6; ea++)
                run((ek == 4) ? "R10" : "R8", 2, ek, ea, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog expired: actual %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule